// File: doc/BRIEF.md
# Exception Entry State Controller

This block performs the architectural state change of a small RISC core when the core takes a reset or an exception. The core presents a one-cycle request that carries a vector index, together with its current program counter, its current status register and a configuration bit. The configuration bit selects full 32-bit program-counter operation or the legacy 26-bit operation. In the legacy form, the program counter shares one register word with the condition flags, the interrupt-disable bits and the mode bits.

On the clock edge after a valid request, the block commits every result of the entry at once:
- the new status register,
- a write of the old status into the saved-status register of the target bank,
- a write of the return value into the link register of that bank,
- the new program counter,
- a one-cycle strobe that tells the core to flush its pipeline.

A request with an index outside the eight defined vectors changes nothing and raises an error flag.

Top module: `trap_entry_ctrl`

## Requirements
- R1: While `rst` is high on a clock edge, with `mode32_i`=1 the outputs become `pc_o`=0 and `psr_o`=0x000000D3. This value has I (bit 7) set, F (bit 6) set and mode field [4:0]=0x13. With `mode32_i`=0 they become `pc_o`=0x0C000003 and `psr_o`=0x000000C3. Strobes and write enables are low.
- R2: Entry always sets the IRQ-disable bit 7. Index 0 (reset) and index 7 (FIQ) also set the FIQ-disable bit 6; every other index keeps bit 6 from the old status. All bits other than 7, 6 and [4:0] are copied from the old status.
- R3: With `mode32_i`=1 the target mode and bank (`bank_o`: 0 supervisor, 1 abort, 2 undefined, 3 IRQ, 4 FIQ) per index are:
  - 0: 0x13 / 0
  - 1: 0x1B / 2
  - 2: 0x13 / 0
  - 3: 0x17 / 1
  - 4: 0x17 / 1
  - 6: 0x12 / 3
  - 7: 0x11 / 4
- R4: With `mode32_i`=0, indexes 0 to 4 enter mode 0x03 with bank 0, index 6 enters 0x02 with bank 3, and index 7 enters 0x01 with bank 4.
- R5: Index 5 (address exception) always enters mode 0x03 with bank 0, whatever `mode32_i` is.
- R6: `sv_data_o` equals the old status `cur_psr_i`, written to bank `bank_o`.
- R7: With `mode32_i`=1 the return value is `cur_pc_i`. `lr_data_o` is that value minus 4 for indexes 1 to 7 and the value unmodified for index 0.
- R8: With `mode32_i`=0 the return value is packed as follows before the same minus-4 rule is applied:
  - bits [31:28] are old flags [31:28];
  - bit 27 is old bit 7;
  - bit 26 is old bit 6;
  - bits [25:2] are `cur_pc_i`[25:2];
  - bits [1:0] are old bits [1:0].
- R9: If the new mode has bit 4 set, `pc_o` is the index times 4. Otherwise `pc_o` is packed from the new status: bits [31:28] are the flags, bit 27 is I, bit 26 is F, bits [25:2] are the index, and bits [1:0] are the mode.
- R10: All results of a valid request appear on the first edge after it. On that same edge `flush_o`, `sv_we_o` and `lr_we_o` are high for exactly one cycle. In cycles that follow no request, all three are low.
- R11: A request with index 8 or above raises `err_o` for one cycle. It leaves `pc_o` and `psr_o` unchanged and asserts no strobe or write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode32_i | input | 1 | 1 = 32-bit PC configuration, 0 = 26-bit packed configuration |
| req_valid_i | input | 1 | One-cycle entry request |
| req_idx_i | input | IDX_W | Vector index of the request |
| cur_pc_i | input | 32 | Current program counter |
| cur_psr_i | input | 32 | Current status register |
| pc_o | output | 32 | New program counter |
| psr_o | output | 32 | New status register |
| flush_o | output | 1 | One-cycle pipeline flush strobe |
| bank_o | output | 3 | Target bank for saved-status and link writes |
| sv_we_o | output | 1 | Saved-status register write enable |
| sv_data_o | output | 32 | Saved-status write data |
| lr_we_o | output | 1 | Link register write enable |
| lr_data_o | output | 32 | Link register write data |
| err_o | output | 1 | Invalid vector index flag |

## Verification
The bench sweeps every index from 0 to 15 under both configurations, against program counters and status words chosen to expose packing faults.

Each corner case targets a specific fault:
- **Address exception.** The bench checks that index 5 stays in 26-bit supervisor mode in the 32-bit configuration. A design that decoded it like the other supervisor entries would return 0x13 and a plain vector PC.
- **Old F bit.** One status pattern already has F set and one has it clear. This separates a design that clears F from one that correctly leaves it alone.
- **Link adjustment.** Reset's unmodified link is compared with the minus-4 link of the other indexes.
- **Invalid indexes.** These must leave the PC and status bit-identical; a design that committed them would overwrite the PC with a garbage vector.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int XW     = 32;
  localparam int NVEC   = 8;
  localparam int I_BIT  = 7;
  localparam int F_BIT  = 6;

  typedef enum logic [2:0] {
    BK_SVC = 3'd0,
    BK_ABT = 3'd1,
    BK_UND = 3'd2,
    BK_IRQ = 3'd3,
    BK_FIQ = 3'd4
  } bank_e;

  localparam logic [4:0] M_FIQ32 = 5'h11;
  localparam logic [4:0] M_IRQ32 = 5'h12;
  localparam logic [4:0] M_SVC32 = 5'h13;
  localparam logic [4:0] M_ABT32 = 5'h17;
  localparam logic [4:0] M_UND32 = 5'h1B;
  localparam logic [4:0] M_FIQ26 = 5'h01;
  localparam logic [4:0] M_IRQ26 = 5'h02;
  localparam logic [4:0] M_SVC26 = 5'h03;

  // Legacy word: flags, I, F, word address, two-bit mode.
  function automatic logic [XW-1:0] pack26(logic [XW-1:0] st, logic [23:0] waddr);
    return {st[31:28], st[I_BIT], st[F_BIT], waddr, st[1:0]};
  endfunction
endpackage

// File: rtl/trap_vec_decode.sv
module trap_vec_decode
  import trap_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             mode32,
  output logic             valid,
  output logic [4:0]       tmode,
  output bank_e            tbank,
  output logic             mask_f
);
  logic [2:0] lo;
  assign lo = idx[2:0];

  generate
    if (IDX_W > 3) begin : g_range
      assign valid = ~|idx[IDX_W-1:3];
    end else begin : g_full
      assign valid = 1'b1;
    end
  endgenerate

  always_comb begin
    tmode  = mode32 ? M_SVC32 : M_SVC26;
    tbank  = BK_SVC;
    mask_f = 1'b0;
    unique case (lo)
      3'd0: mask_f = 1'b1;
      3'd1: if (mode32) begin tmode = M_UND32; tbank = BK_UND; end
      3'd2: ;
      3'd3, 3'd4: if (mode32) begin tmode = M_ABT32; tbank = BK_ABT; end
      3'd5: tmode = M_SVC26;
      3'd6: begin tmode = mode32 ? M_IRQ32 : M_IRQ26; tbank = BK_IRQ; end
      3'd7: begin tmode = mode32 ? M_FIQ32 : M_FIQ26; tbank = BK_FIQ; mask_f = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/trap_link_calc.sv
module trap_link_calc
  import trap_pkg::*;
#(
  parameter int ADJ = 4
) (
  input  logic          mode32,
  input  logic          is_reset,
  input  logic [XW-1:0] pc,
  input  logic [XW-1:0] psr,
  output logic [XW-1:0] link
);
  logic [XW-1:0] base;
  assign base = mode32 ? pc : pack26(psr, pc[25:2]);
  assign link = is_reset ? base : base - XW'(ADJ);
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode32_i,
  input  logic             req_valid_i,
  input  logic [IDX_W-1:0] req_idx_i,
  input  logic [31:0]      cur_pc_i,
  input  logic [31:0]      cur_psr_i,
  output logic [31:0]      pc_o,
  output logic [31:0]      psr_o,
  output logic             flush_o,
  output logic [2:0]       bank_o,
  output logic             sv_we_o,
  output logic [31:0]      sv_data_o,
  output logic             lr_we_o,
  output logic [31:0]      lr_data_o,
  output logic             err_o
);
  localparam logic [XW-1:0] RST_PSR32 = XW'({1'b1, 1'b1, 1'b0, M_SVC32});
  localparam logic [XW-1:0] RST_PSR26 = XW'({1'b1, 1'b1, 1'b0, M_SVC26});

  logic          d_valid, d_maskf;
  logic [4:0]    d_mode;
  bank_e         d_bank;
  logic [XW-1:0] link, npsr, npc;
  logic [2:0]    lo;

  assign lo = req_idx_i[2:0];

  trap_vec_decode #(.IDX_W(IDX_W)) u_dec (
    .idx(req_idx_i), .mode32(mode32_i), .valid(d_valid),
    .tmode(d_mode), .tbank(d_bank), .mask_f(d_maskf)
  );

  trap_link_calc #(.ADJ(4)) u_link (
    .mode32(mode32_i), .is_reset(lo == 3'd0), .pc(cur_pc_i),
    .psr(cur_psr_i), .link(link)
  );

  always_comb begin
    npsr        = cur_psr_i;
    npsr[I_BIT] = 1'b1;
    if (d_maskf) npsr[F_BIT] = 1'b1;
    npsr[4:0]   = d_mode;
    npc = d_mode[4] ? XW'({lo, 2'b00}) : pack26(npsr, 24'(lo));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_o      <= mode32_i ? '0 : pack26(RST_PSR26, '0);
      psr_o     <= mode32_i ? RST_PSR32 : RST_PSR26;
      flush_o   <= 1'b0;
      sv_we_o   <= 1'b0;
      lr_we_o   <= 1'b0;
      err_o     <= 1'b0;
      bank_o    <= BK_SVC;
      sv_data_o <= '0;
      lr_data_o <= '0;
    end else begin
      flush_o <= 1'b0;
      sv_we_o <= 1'b0;
      lr_we_o <= 1'b0;
      err_o   <= 1'b0;
      if (req_valid_i) begin
        if (d_valid) begin
          pc_o      <= npc;
          psr_o     <= npsr;
          bank_o    <= d_bank;
          sv_data_o <= cur_psr_i;
          lr_data_o <= link;
          flush_o   <= 1'b1;
          sv_we_o   <= 1'b1;
          lr_we_o   <= 1'b1;
        end else begin
          err_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/trap_entry_ctrl_chk.sv
module trap_entry_ctrl_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             mode32_i,
  input logic             req_valid_i,
  input logic [IDX_W-1:0] req_idx_i,
  input logic [31:0]      cur_psr_i,
  input logic [31:0]      pc_o,
  input logic [31:0]      psr_o,
  input logic             flush_o,
  input logic [2:0]       bank_o,
  input logic             sv_we_o,
  input logic [31:0]      sv_data_o,
  input logic             lr_we_o,
  input logic             err_o
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && $past(mode32_i)) |-> (pc_o == 32'h0 && psr_o == 32'hD3));

  assert_irq_masked_R2: assert property (@(posedge clk) disable iff (rst)
    flush_o |-> psr_o[7]);

  assert_fiq_masked_R2: assert property (@(posedge clk) disable iff (rst)
    (flush_o && ($past(req_idx_i) == IDX_W'(0) || $past(req_idx_i) == IDX_W'(7))) |-> psr_o[6]);

  assert_addr_exc_R5: assert property (@(posedge clk) disable iff (rst)
    (flush_o && $past(req_idx_i) == IDX_W'(5)) |-> (psr_o[4:0] == 5'h03 && bank_o == 3'd0));

  assert_saved_psr_R6: assert property (@(posedge clk) disable iff (rst)
    sv_we_o |-> sv_data_o == $past(cur_psr_i));

  assert_vector_pc_R9: assert property (@(posedge clk) disable iff (rst)
    (flush_o && psr_o[4]) |-> pc_o == 32'({$past(req_idx_i), 2'b00}));

  assert_atomic_R10: assert property (@(posedge clk) disable iff (rst)
    flush_o |-> (sv_we_o && lr_we_o && !err_o));

  assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(req_valid_i) |-> (!flush_o && !err_o && !sv_we_o && !lr_we_o));

  assert_invalid_R11: assert property (@(posedge clk) disable iff (rst)
    ($past(req_valid_i) && !$past(rst) && $past(req_idx_i) >= IDX_W'(8))
      |-> (err_o && !flush_o && $stable(pc_o) && $stable(psr_o)));
endmodule

bind trap_entry_ctrl trap_entry_ctrl_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/trap_entry_ctrl_bench.sv
module trap_entry_ctrl_bench;
  localparam int IDX_W = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             mode32_i = 1'b1;
  logic             req_valid_i = 1'b0;
  logic [IDX_W-1:0] req_idx_i = '0;
  logic [31:0]      cur_pc_i = '0;
  logic [31:0]      cur_psr_i = '0;
  logic [31:0]      pc_o, psr_o, sv_data_o, lr_data_o;
  logic [2:0]       bank_o;
  logic             flush_o, sv_we_o, lr_we_o, err_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  trap_entry_ctrl #(.IDX_W(IDX_W)) u_trap_entry_ctrl (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic do_req(bit cfg, int idx, logic [31:0] pc, logic [31:0] st);
    logic [31:0] pre_pc, pre_psr, enp, base, elr, epc;
    logic [4:0]  em;
    logic [2:0]  eb;
    bit          fm;
    @(negedge clk);
    pre_pc  = pc_o;
    pre_psr = psr_o;
    mode32_i = cfg; req_idx_i = IDX_W'(idx); cur_pc_i = pc; cur_psr_i = st;
    req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    if (idx >= 8) begin
      chk("R11 err", 32'(err_o), 1);
      chk("R11 pc kept", pc_o, pre_pc);
      chk("R11 psr kept", psr_o, pre_psr);
      chk("R11 no strobe", {29'b0, flush_o, sv_we_o, lr_we_o}, 0);
    end else begin
      fm = (idx == 0 || idx == 7);
      case (idx)
        1:       begin em = cfg ? 5'h1B : 5'h03; eb = cfg ? 3'd2 : 3'd0; end
        3, 4:    begin em = cfg ? 5'h17 : 5'h03; eb = cfg ? 3'd1 : 3'd0; end
        5:       begin em = 5'h03; eb = 3'd0; end
        6:       begin em = cfg ? 5'h12 : 5'h02; eb = 3'd3; end
        7:       begin em = cfg ? 5'h11 : 5'h01; eb = 3'd4; end
        default: begin em = cfg ? 5'h13 : 5'h03; eb = 3'd0; end
      endcase
      enp = (st & ~32'h1F) | 32'h80 | (fm ? 32'h40 : 32'h0) | 32'(em);
      base = cfg ? pc : {st[31:28], st[7], st[6], pc[25:2], st[1:0]};
      elr = (idx == 0) ? base : base - 32'd4;
      epc = em[4] ? 32'(idx * 4) : {enp[31:28], enp[7], enp[6], 24'(idx), enp[1:0]};
      chk("R2 mask bits", 32'(psr_o[7:6]), 32'(enp[7:6]));
      chk("R2 kept bits", psr_o, enp);
      if (idx == 5) begin
        chk("R5 mode", 32'(psr_o[4:0]), 32'(em));
        chk("R5 bank", 32'(bank_o), 32'(eb));
      end else if (cfg) begin
        chk("R3 mode", 32'(psr_o[4:0]), 32'(em));
        chk("R3 bank", 32'(bank_o), 32'(eb));
      end else begin
        chk("R4 mode", 32'(psr_o[4:0]), 32'(em));
        chk("R4 bank", 32'(bank_o), 32'(eb));
      end
      chk("R6 saved psr", sv_data_o, st);
      if (cfg) chk("R7 link", lr_data_o, elr);
      else     chk("R8 packed link", lr_data_o, elr);
      chk("R9 new pc", pc_o, epc);
      chk("R10 strobes", {29'b0, flush_o, sv_we_o, lr_we_o, err_o} >> 1, 32'h7);
    end
    @(negedge clk);
    chk("R10 idle", {28'b0, flush_o, sv_we_o, lr_we_o, err_o}, 0);
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    logic [31:0] pcs [4];
    logic [31:0] sts [3];
    pcs = '{32'h0000_1000, 32'h03FF_FFFC, 32'h8000_0004, 32'h0123_4568};
    sts = '{32'hF000_0010, 32'h6000_0053, 32'hA000_0040};
    rst = 1'b1; mode32_i = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 pc32", pc_o, 32'h0);
    chk("R1 psr32", psr_o, 32'hD3);
    chk("R1 strobes", {28'b0, flush_o, sv_we_o, lr_we_o, err_o}, 0);
    mode32_i = 1'b0;
    @(negedge clk);
    chk("R1 pc26", pc_o, 32'h0C00_0003);
    chk("R1 psr26", psr_o, 32'hC3);
    rst = 1'b0;
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < 16; i++)
        for (int p = 0; p < 4; p++)
          do_req(c[0], i, pcs[p], sts[p % 3]);
    finish_run();
  end
endmodule